// File: doc/BRIEF.md
# Register-Based Call/Return Sequencer

This block carries out the execute phase of the two subroutine-linkage instructions of a core that has sixteen 16-bit general registers. Any of them can serve as program counter (selected by `sel_p`), stack pointer (`sel_x`) or link register (`sel_n`). On a call, the sequencer pushes the link register onto a stack that grows downward. It then copies the program counter into the link register and loads a new program counter from the two in-line bytes that follow. On a return, it copies the link register back into the program counter and pops the saved link value off the stack.

The instructions take two opcode bytes: prefix 0x68, then 0x8N for a call or 0x9N for a return. The two opcode fetches sit outside this block. After them, a call spends 8 execute cycles here and a return spends 6, for totals of 10 and 8 machine cycles. The block drives the register file through one combinational read port and one write port. It drives memory through a byte-wide port whose read data returns in the same cycle. In every cycle it performs at most one memory access and at most one register write.

The execute sequence is built on named states:
- Call path: `ST_C_SP` (read stack pointer), `ST_C_LO` (store the low byte of the link), `ST_C_HI` (store the high byte of the link and write back SP-2), `ST_C_LINK` (copy PC into the link), `ST_C_FH` and `ST_C_FL` (fetch the target high and low bytes), `ST_C_PC` (load PC), `ST_C_ADV` (write link+2).
- Return path: `ST_R_PC` (copy the link into PC), `ST_R_SP` (read SP), `ST_R_FH` and `ST_R_FL` (pop the high and low bytes), `ST_R_LINK` (restore the link), `ST_R_ADV` (write SP+2).

`ST_IDLE` leaves on `start`, taking the call path when `op_call` is 1 and the return path otherwise. Each path moves through its states in the order listed, one per cycle, and returns to `ST_IDLE` after its last state. The temporary register holds no defined value after either instruction.

Top module: `call_ret_seq`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `mem_re`, `mem_we` and `rf_we` are all 0.
- R2: A start with `op_call`=1 keeps `busy` high for exactly 8 cycles. A start with `op_call`=0 keeps it high for exactly 6 cycles. `busy` rises in the cycle after the start is sampled.
- R3: A call writes the low byte of R(N) to address R(X) and then the high byte to address R(X)-1. It leaves R(X) decremented by 2.
- R4: After a call, R(P) holds {M(old R(P)), M(old R(P)+1)}, with the first byte as the high byte. R(N) holds old R(P)+2.
- R5: After a return, R(P) holds the old R(N), R(N) holds {M(R(X)+1), M(R(X)+2)} with the first byte high, and R(X) is incremented by 2.
- R6: No cycle asserts both `mem_re` and `mem_we`. A call makes exactly 2 memory writes, 2 memory reads and 4 register writes. A return makes 0 memory writes, 2 memory reads and 3 register writes. No strobe is active while idle.
- R7: A `start` raised while `busy` is high has no effect. The running instruction completes with its original selectors, and no further instruction follows it.
- R8: All pointer arithmetic wraps modulo 2^16. A call with R(X)=0x0000 stores at 0x0000 and 0xFFFF and leaves R(X)=0xFFFE, and the matching return restores R(X)=0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction; sampled only while idle |
| op_call | input | 1 | 1 = call, 0 = return |
| sel_p | input | 4 | Program-counter register number |
| sel_x | input | 4 | Stack-pointer register number |
| sel_n | input | 4 | Link register number |
| busy | output | 1 | High during every execute cycle |
| rf_raddr | output | 4 | Register-file read address |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write address |
| rf_wdata | output | 16 | Register-file write data |
| mem_addr | output | 16 | Memory byte address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid in the same cycle |

## Verification
The assertions assume that the three selectors name three different registers. If any two of them alias, the order of reads and writes is still fixed, but the resulting register values are no longer the ones R3 to R5 give. They also assume that register writes land at the clock edge and that memory read data arrives in the same cycle. Every directed scenario picks distinct P, X and N. The bench models the register file and memory with exactly that timing. The ignored-start scenario uses aliased selectors only on the stray request, which must never be latched.

// File: rtl/crs_pkg.sv
package crs_pkg;
    localparam int CALL_EXEC = 8;
    localparam int RET_EXEC  = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_C_SP, ST_C_LO, ST_C_HI, ST_C_LINK, ST_C_FH, ST_C_FL, ST_C_PC, ST_C_ADV,
        ST_R_PC, ST_R_SP, ST_R_FH, ST_R_FL, ST_R_LINK, ST_R_ADV
    } seq_state_e;
endpackage

// File: rtl/crs_ctrl.sv
module crs_ctrl
    import crs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       op_call,
    output seq_state_e state,
    output logic       busy
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = op_call ? ST_C_SP : ST_R_PC;
            ST_C_SP:   state_d = ST_C_LO;
            ST_C_LO:   state_d = ST_C_HI;
            ST_C_HI:   state_d = ST_C_LINK;
            ST_C_LINK: state_d = ST_C_FH;
            ST_C_FH:   state_d = ST_C_FL;
            ST_C_FL:   state_d = ST_C_PC;
            ST_C_PC:   state_d = ST_C_ADV;
            ST_C_ADV:  state_d = ST_IDLE;
            ST_R_PC:   state_d = ST_R_SP;
            ST_R_SP:   state_d = ST_R_FH;
            ST_R_FH:   state_d = ST_R_FL;
            ST_R_FL:   state_d = ST_R_LINK;
            ST_R_LINK: state_d = ST_R_ADV;
            ST_R_ADV:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;
    assign busy  = (state_q != ST_IDLE);

    // Execute-length checker: counts busy cycles of the running instruction.
    logic [3:0] run_q;
    logic       call_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            call_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            run_q  <= '0;
            call_q <= op_call;
        end else begin
            run_q  <= run_q + 4'd1;
        end
    end

    // R2: the last execute cycle lands on the instruction's fixed length
    a_r2_exec_length: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_d == ST_IDLE) |->
            run_q == (call_q ? 4'(CALL_EXEC - 1) : 4'(RET_EXEC - 1)));

    // R1: reset leaves the sequencer idle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !busy);
endmodule

// File: rtl/crs_datapath.sv
module crs_datapath
    import crs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 4,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              start,
    input  logic [SEL_W-1:0]  sel_p,
    input  logic [SEL_W-1:0]  sel_x,
    input  logic [SEL_W-1:0]  sel_n,
    output logic [SEL_W-1:0]  rf_raddr,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [SEL_W-1:0]  rf_waddr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    logic [SEL_W-1:0]  p_q, x_q, n_q;
    logic [WORD_W-1:0] ptr_q;
    logic [WORD_W-1:0] tmp_q;

    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);
    localparam logic [WORD_W-1:0] TWO = WORD_W'(2);

    // State-dependent register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q   <= '0;
            x_q   <= '0;
            n_q   <= '0;
            ptr_q <= '0;
            tmp_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    p_q <= sel_p;
                    x_q <= sel_x;
                    n_q <= sel_n;
                end
                ST_C_SP, ST_R_SP: ptr_q <= rf_rdata;
                ST_C_LO:          tmp_q <= rf_rdata;
                ST_C_LINK:        ptr_q <= rf_rdata;
                ST_C_FH, ST_R_FH: tmp_q[WORD_W-1:BYTE_W] <= mem_rdata;
                ST_C_FL, ST_R_FL: tmp_q[BYTE_W-1:0]      <= mem_rdata;
                default: ;
            endcase
        end
    end

    // Port outputs per state
    always_comb begin
        rf_raddr  = '0;
        rf_we     = 1'b0;
        rf_waddr  = '0;
        rf_wdata  = '0;
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            ST_C_SP: rf_raddr = x_q;
            ST_C_LO: begin
                rf_raddr  = n_q;
                mem_we    = 1'b1;
                mem_addr  = ptr_q;
                mem_wdata = rf_rdata[BYTE_W-1:0];
            end
            ST_C_HI: begin
                mem_we    = 1'b1;
                mem_addr  = ptr_q - ONE;
                mem_wdata = tmp_q[WORD_W-1:BYTE_W];
                rf_we     = 1'b1;
                rf_waddr  = x_q;
                rf_wdata  = ptr_q - TWO;
            end
            ST_C_LINK: begin
                rf_raddr = p_q;
                rf_we    = 1'b1;
                rf_waddr = n_q;
                rf_wdata = rf_rdata;
            end
            ST_C_FH: begin
                mem_re   = 1'b1;
                mem_addr = ptr_q;
            end
            ST_C_FL: begin
                mem_re   = 1'b1;
                mem_addr = ptr_q + ONE;
            end
            ST_C_PC: begin
                rf_we    = 1'b1;
                rf_waddr = p_q;
                rf_wdata = tmp_q;
            end
            ST_C_ADV: begin
                rf_we    = 1'b1;
                rf_waddr = n_q;
                rf_wdata = ptr_q + TWO;
            end
            ST_R_PC: begin
                rf_raddr = n_q;
                rf_we    = 1'b1;
                rf_waddr = p_q;
                rf_wdata = rf_rdata;
            end
            ST_R_SP: rf_raddr = x_q;
            ST_R_FH: begin
                mem_re   = 1'b1;
                mem_addr = ptr_q + ONE;
            end
            ST_R_FL: begin
                mem_re   = 1'b1;
                mem_addr = ptr_q + TWO;
            end
            ST_R_LINK: begin
                rf_we    = 1'b1;
                rf_waddr = n_q;
                rf_wdata = tmp_q;
            end
            ST_R_ADV: begin
                rf_we    = 1'b1;
                rf_waddr = x_q;
                rf_wdata = ptr_q + TWO;
            end
            default: ;
        endcase
    end

    // R6: one memory access per cycle
    a_r6_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R6: quiet ports while idle
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mem_re && !mem_we && !rf_we));

    // R3: back-to-back stores descend by one byte
    a_r3_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - ONE));

    // R7: selectors are frozen for the whole execute phase
    a_r7_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |->
            ($stable(p_q) && $stable(x_q) && $stable(n_q)));
endmodule

// File: rtl/call_ret_seq.sv
module call_ret_seq
    import crs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 4,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_call,
    input  logic [SEL_W-1:0]  sel_p,
    input  logic [SEL_W-1:0]  sel_x,
    input  logic [SEL_W-1:0]  sel_n,
    output logic              busy,
    output logic [SEL_W-1:0]  rf_raddr,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [SEL_W-1:0]  rf_waddr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    seq_state_e state;

    crs_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_call (op_call),
        .state   (state),
        .busy    (busy)
    );

    crs_datapath #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .start     (start),
        .sel_p     (sel_p),
        .sel_x     (sel_x),
        .sel_n     (sel_n),
        .rf_raddr  (rf_raddr),
        .rf_rdata  (rf_rdata),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );
endmodule

// File: tb/tb_call_ret_seq.sv
module tb_call_ret_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_call = 1'b0;
    logic [3:0]  sel_p = '0, sel_x = '0, sel_n = '0;
    logic        busy;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [15:0] rf_rdata, rf_wdata, mem_addr;
    logic        rf_we, mem_re, mem_we;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [15:0] regs [16];
    logic [7:0]  mem  [256];

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int cyc, n_mw, n_mr, n_rw, n_both;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rdata  = regs[rf_raddr];
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (rf_we)  regs[rf_waddr]     <= rf_wdata;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    call_ret_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_call(op_call),
        .sel_p(sel_p), .sel_x(sel_x), .sel_n(sel_n), .busy(busy),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Runs one instruction; optionally pulses a stray start mid-run.
    task automatic run_op(input logic is_call, input logic [3:0] p, input logic [3:0] x,
                          input logic [3:0] n, input bit stray);
        @(negedge clk);
        op_call = is_call; sel_p = p; sel_x = x; sel_n = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; n_mw = 0; n_mr = 0; n_rw = 0; n_both = 0;
        while (busy && cyc < 40) begin
            cyc++;
            if (mem_we) n_mw++;
            if (mem_re) n_mr++;
            if (rf_we)  n_rw++;
            if (mem_we && mem_re) n_both++;
            if (stray && cyc == 2) begin
                op_call = ~is_call; sel_p = x; sel_x = x; sel_n = x; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 busy in reset", busy, 0);
        check("R1 strobes in reset", {mem_re, mem_we, rf_we}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 strobes after reset", {mem_re, mem_we, rf_we}, 0);
    endtask

    task automatic t_call_basic;
        regs[3] = 16'h0010; regs[2] = 16'h0080; regs[6] = 16'hBEEF;
        mem[8'h10] = 8'h12; mem[8'h11] = 8'h34;
        run_op(1'b1, 4'd3, 4'd2, 4'd6, 0);
        check("R2 call length", cyc, 8);
        check("R3 low byte at R(X)", mem[8'h80], 8'hEF);
        check("R3 high byte at R(X)-1", mem[8'h7F], 8'hBE);
        check("R3 R(X) minus 2", regs[2], 16'h007E);
        check("R4 new PC", regs[3], 16'h1234);
        check("R4 link = old PC + 2", regs[6], 16'h0012);
        check("R6 call mem writes", n_mw, 2);
        check("R6 call mem reads", n_mr, 2);
        check("R6 call reg writes", n_rw, 4);
        check("R6 no dual access", n_both, 0);
        check("R6 idle quiet", {mem_re, mem_we, rf_we}, 0);
    endtask

    task automatic t_return_basic;
        run_op(1'b0, 4'd3, 4'd2, 4'd6, 0);
        check("R2 return length", cyc, 6);
        check("R5 PC = old link", regs[3], 16'h0012);
        check("R5 link popped", regs[6], 16'hBEEF);
        check("R5 R(X) plus 2", regs[2], 16'h0080);
        check("R6 return mem writes", n_mw, 0);
        check("R6 return mem reads", n_mr, 2);
        check("R6 return reg writes", n_rw, 3);
    endtask

    task automatic t_wrap;
        regs[9] = 16'h0020; regs[1] = 16'h0000; regs[4] = 16'hA5C3;
        mem[8'h20] = 8'h44; mem[8'h21] = 8'h55;
        run_op(1'b1, 4'd9, 4'd1, 4'd4, 0);
        check("R8 low byte at 0x0000", mem[8'h00], 8'hC3);
        check("R8 high byte at 0xFFFF", mem[8'hFF], 8'hA5);
        check("R8 R(X) wraps to 0xFFFE", regs[1], 16'hFFFE);
        check("R8 new PC", regs[9], 16'h4455);
        run_op(1'b0, 4'd9, 4'd1, 4'd4, 0);
        check("R8 R(X) wraps back to 0", regs[1], 16'h0000);
        check("R8 link restored", regs[4], 16'hA5C3);
        check("R8 PC restored", regs[9], 16'h0022);
    endtask

    task automatic t_stray_start;
        regs[7] = 16'h0030; regs[5] = 16'h0040; regs[8] = 16'h1357;
        mem[8'h30] = 8'h9A; mem[8'h31] = 8'hBC;
        run_op(1'b1, 4'd7, 4'd5, 4'd8, 1);
        check("R7 call length kept", cyc, 8);
        check("R7 PC loaded", regs[7], 16'h9ABC);
        check("R7 link updated", regs[8], 16'h0032);
        check("R7 R(X) minus 2", regs[5], 16'h003E);
        check("R7 pushed bytes", {mem[8'h3F], mem[8'h40]}, 16'h1357);
        @(negedge clk);
        check("R7 no follow-on op", busy, 0);
        check("R7 stack untouched after", regs[5], 16'h003E);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 16'h0000;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        @(negedge clk);
        t_reset();
        t_call_basic();
        t_return_basic();
        t_wrap();
        t_stray_start();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule